// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block collects a vector of level-sensitive interrupt sources and drives two request lines toward a processor: a normal request and a fast request. Each line has its own enable mask. A mask is changed through a pair of write words: one sets the bits written as 1 and the other clears them. Software reads masked status, raw status and the masks through a simple synchronous word-addressed register port. It can also raise an interrupt of its own through a pending flag, which is merged into raw level bit 0.

Each request line is the OR of the sources that are pending and enabled for it. There is no priority, no vector and no edge capture. The lines are registered. A second instance can be cascaded by tying the normal request of one controller to a source input of another.

A register access is a single cycle with `req_i` high. A read returns its data on `rdata_o` in the cycle after the request, and `rdata_o` holds that value until the next read. Writes take effect at the clock edge that samples the request.

Top module: `ic_level_ctrl`

## Requirements
- R1: Reading word 1 or word 9 returns the raw level vector. Bit n is high when `src_i[n]` is high. Bit 0 is also high while the software pending flag is set.
- R2: Reading word 0 returns raw AND normal-enable. Reading word 8 returns raw AND fast-enable.
- R3: A write to word 2 ORs the write data into the normal-enable mask. A write to word 3 clears the mask bits written as 1. Reading word 2 returns the mask.
- R4: A write to word 10 ORs the write data into the fast-enable mask. A write to word 11 clears the mask bits written as 1. Reading word 10 returns the mask.
- R5: A write to word 4 with data bit 0 at 1 sets the software pending flag. A write to word 5 with data bit 0 at 1 clears it. A write with data bit 0 at 0 leaves the flag unchanged. Reading word 4 returns raw bit 0 in bit 0 and zero in every other bit.
- R6: `irq_o` is high exactly when raw AND normal-enable was non-zero at the previous clock edge.
- R7: `fiq_o` is high exactly when raw AND fast-enable was non-zero at the previous clock edge.
- R8: Reads of words 3, 5 and 11, and of any word not named above, return zero.
- R9: Writes to words 0, 1, 8 and 9, and to any word not named above, change neither mask nor the software pending flag.
- R10: After reset both masks and the software flag are zero, and `irq_o`, `fiq_o` and `rdata_o` are low.
- R11: An enable write at clock edge k changes the request output at edge k+1, not at edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | N_SRC | Level interrupt sources |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid the cycle after a read |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
Hardware source 0 and the software pending flag share raw bit 0, so they can change in the same cycle. The bench drops `src_i[0]` in the same cycle as a software-clear write and checks that raw bit 0 and both request lines fall. It then sets the flag while source 0 is high, releases the source, and checks that bit 0 stays high. Random source changes are also mixed with enable writes in the same cycles. After each such cycle the outputs and the readback are compared against a bench model of both masks and the flag.

// File: rtl/ic_level_pkg.sv
package ic_level_pkg;
  localparam int unsigned W_IRQ_STAT = 0;
  localparam int unsigned W_RAW      = 1;
  localparam int unsigned W_IRQ_SET  = 2;
  localparam int unsigned W_IRQ_CLR  = 3;
  localparam int unsigned W_SW_SET   = 4;
  localparam int unsigned W_SW_CLR   = 5;
  localparam int unsigned W_FIQ_STAT = 8;
  localparam int unsigned W_FIQ_RAW  = 9;
  localparam int unsigned W_FIQ_SET  = 10;
  localparam int unsigned W_FIQ_CLR  = 11;

  localparam int unsigned N_CHAN = 2;  // 0: normal, 1: fast

  typedef struct packed {
    logic [N_CHAN-1:0] en_set;
    logic [N_CHAN-1:0] en_clr;
    logic              sw_set;
    logic              sw_clr;
  } wr_dec_t;
endpackage

// File: rtl/ic_mask_reg.sv
module ic_mask_reg #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [N_SRC-1:0] bits_i,
  output logic [N_SRC-1:0] mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    mask_o <= '0;
    else if (set_i) mask_o <= mask_o | bits_i;
    else if (clr_i) mask_o <= mask_o & ~bits_i;
  end
endmodule

// File: rtl/ic_sw_pend.sv
module ic_sw_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  input  logic bit_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pend_o <= 1'b0;
    else if (set_i && bit_i)   pend_o <= 1'b1;
    else if (clr_i && bit_i)   pend_o <= 1'b0;
  end
endmodule

// File: rtl/ic_out_stage.sv
module ic_out_stage #(
  parameter int unsigned N_SRC = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] level_i,
  input  logic [N_SRC-1:0] mask_i,
  output logic             req_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_o <= 1'b0;
    else         req_o <= |(level_i & mask_i);
  end
endmodule

// File: rtl/ic_regif.sv
module ic_regif
  import ic_level_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_SRC-1:0]  level_i,
  input  logic [N_SRC-1:0]  irq_en_i,
  input  logic [N_SRC-1:0]  fiq_en_i,
  output wr_dec_t           dec_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic wr, rd;
  logic [DATA_W-1:0] rd_mux;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_comb begin
    dec_o           = '0;
    dec_o.en_set[0] = wr && (addr_i == ADDR_W'(W_IRQ_SET));
    dec_o.en_clr[0] = wr && (addr_i == ADDR_W'(W_IRQ_CLR));
    dec_o.en_set[1] = wr && (addr_i == ADDR_W'(W_FIQ_SET));
    dec_o.en_clr[1] = wr && (addr_i == ADDR_W'(W_FIQ_CLR));
    dec_o.sw_set    = wr && (addr_i == ADDR_W'(W_SW_SET));
    dec_o.sw_clr    = wr && (addr_i == ADDR_W'(W_SW_CLR));
  end

  always_comb begin
    rd_mux = '0;
    if      (addr_i == ADDR_W'(W_IRQ_STAT)) rd_mux = DATA_W'(level_i & irq_en_i);
    else if (addr_i == ADDR_W'(W_RAW))      rd_mux = DATA_W'(level_i);
    else if (addr_i == ADDR_W'(W_IRQ_SET))  rd_mux = DATA_W'(irq_en_i);
    else if (addr_i == ADDR_W'(W_SW_SET))   rd_mux = DATA_W'(level_i[0]);
    else if (addr_i == ADDR_W'(W_FIQ_STAT)) rd_mux = DATA_W'(level_i & fiq_en_i);
    else if (addr_i == ADDR_W'(W_FIQ_RAW))  rd_mux = DATA_W'(level_i);
    else if (addr_i == ADDR_W'(W_FIQ_SET))  rd_mux = DATA_W'(fiq_en_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_o <= '0;
    else if (rd)  rdata_o <= rd_mux;
  end
endmodule

// File: rtl/ic_level_ctrl.sv
module ic_level_ctrl
  import ic_level_pkg::*;
#(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              fiq_o
);
  wr_dec_t          dec;
  logic             sw_pend;
  logic [N_SRC-1:0] level;
  logic [N_SRC-1:0] wbits;
  logic [N_SRC-1:0] en_q [N_CHAN];
  logic [N_CHAN-1:0] req_q;
  logic [N_SRC-1:0] irq_en, fiq_en;

  assign wbits  = wdata_i[N_SRC-1:0];
  assign level  = src_i | {{(N_SRC-1){1'b0}}, sw_pend};
  assign irq_en = en_q[0];
  assign fiq_en = en_q[1];
  assign irq_o  = req_q[0];
  assign fiq_o  = req_q[1];

  ic_regif #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regif (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i,
    .level_i(level), .irq_en_i(irq_en), .fiq_en_i(fiq_en),
    .dec_o(dec), .rdata_o
  );

  ic_sw_pend u_sw (
    .clk_i, .rst_ni, .set_i(dec.sw_set), .clr_i(dec.sw_clr),
    .bit_i(wdata_i[0]), .pend_o(sw_pend)
  );

  for (genvar c = 0; c < N_CHAN; c++) begin : g_chan
    ic_mask_reg #(.N_SRC(N_SRC)) u_mask (
      .clk_i, .rst_ni, .set_i(dec.en_set[c]), .clr_i(dec.en_clr[c]),
      .bits_i(wbits), .mask_o(en_q[c])
    );
    ic_out_stage #(.N_SRC(N_SRC)) u_out (
      .clk_i, .rst_ni, .level_i(level), .mask_i(en_q[c]), .req_o(req_q[c])
    );
  end
endmodule

// File: rtl/ic_level_ctrl_chk.sv
module ic_level_ctrl_chk #(
  parameter int unsigned N_SRC  = 32,
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [N_SRC-1:0]  level,
  input logic [N_SRC-1:0]  irq_en,
  input logic [N_SRC-1:0]  fiq_en,
  input logic              sw_pend,
  input logic              irq_o,
  input logic              fiq_o
);
  // R6
  irq_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> irq_o == $past(|(level & irq_en)));
  // R7
  fiq_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> fiq_o == $past(|(level & fiq_en)));
  // R3
  irq_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(2)) |=>
      (irq_en & $past(wdata_i[N_SRC-1:0])) == $past(wdata_i[N_SRC-1:0]));
  // R3
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(3)) |=> (irq_en & $past(wdata_i[N_SRC-1:0])) == '0);
  // R4
  fiq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(11)) |=> (fiq_en & $past(wdata_i[N_SRC-1:0])) == '0);
  // R5
  sw_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(4) && wdata_i[0]) |=> sw_pend);
  // R9
  ro_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && (addr_i == ADDR_W'(0) || addr_i == ADDR_W'(1) ||
                       addr_i == ADDR_W'(8) || addr_i == ADDR_W'(9))) |=>
      $stable(irq_en) && $stable(fiq_en) && $stable(sw_pend));
  // R8
  wo_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && (addr_i == ADDR_W'(3) || addr_i == ADDR_W'(5) ||
                        addr_i == ADDR_W'(11))) |=> rdata_o == '0);
endmodule

bind ic_level_ctrl ic_level_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .level(level), .irq_en(irq_en),
  .fiq_en(fiq_en), .sw_pend(sw_pend), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/ic_level_ctrl_test.sv
`timescale 1ns/1ps
module ic_level_ctrl_test;
  localparam int N = 32;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] src = '0;
  logic req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq, fiq;

  int checks = 0, fails = 0;
  bit done = 0;

  logic [N-1:0] m_ie = '0, m_fe = '0;
  logic m_sw = 0;

  always #2.5 clk = ~clk;

  ic_level_ctrl #(.N_SRC(N), .ADDR_W(AW), .DATA_W(32)) uut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  function automatic logic [N-1:0] m_lvl();
    return src | {{(N-1){1'b0}}, m_sw};
  endfunction

  function automatic logic [31:0] exp_rd(int a);
    case (a)
      0: return m_lvl() & m_ie;
      1, 9: return m_lvl();
      2: return m_ie;
      4: return {31'd0, m_lvl()[0]};
      8: return m_lvl() & m_fe;
      10: return m_fe;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(int a);
    case (a)
      0, 8: return "R2";
      1, 9: return "R1";
      2: return "R3";
      10: return "R4";
      4: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic m_write(int a, logic [31:0] d);
    case (a)
      2: m_ie |= d;
      3: m_ie &= ~d;
      4: if (d[0]) m_sw = 1;
      5: if (d[0]) m_sw = 0;
      10: m_fe |= d;
      11: m_fe &= ~d;
      default: ;
    endcase
  endtask

  // returns at the negedge after the sampling edge
  task automatic wr(int a, logic [31:0] d);
    req = 1; we = 1; addr = AW'(a); wdata = d;
    @(posedge clk); @(negedge clk);
    req = 0; we = 0;
    m_write(a, d);
  endtask

  task automatic rd(int a);
    req = 1; we = 0; addr = AW'(a);
    @(posedge clk); @(negedge clk);
    req = 0;
    chk(rd_tag(a), rdata, exp_rd(a));
  endtask

  task automatic idle_chk_out();
    @(posedge clk); @(negedge clk);
    chk("R6", {31'd0, irq}, {31'd0, |(m_lvl() & m_ie)});
    chk("R7", {31'd0, fiq}, {31'd0, |(m_lvl() & m_fe)});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int alist [16] = '{0, 1, 2, 3, 4, 5, 8, 9, 10, 11, 6, 7, 12, 20, 33, 63};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", {30'd0, irq, fiq}, 32'd0);
    chk("R10", rdata, 32'd0);
    rst_n = 1;
    @(negedge clk);
    rd(2); rd(10); rd(1);
    chk("R10", {30'd0, irq, fiq}, 32'd0);

    // R11: output lags the enable write by one edge
    src = 32'h0000_0100;
    wr(2, 32'h0000_0100);
    chk("R11", {31'd0, irq}, 32'd0);
    idle_chk_out();
    chk("R11", {31'd0, irq}, 32'd1);

    // R9: writes to status/undefined words leave state alone
    wr(0, '1); wr(1, '1); wr(8, '1); wr(9, '1); wr(40, '1);
    req = 1; we = 0; addr = AW'(2); @(posedge clk); @(negedge clk); req = 0;
    chk("R9", rdata, m_ie);
    req = 1; addr = AW'(10); @(posedge clk); @(negedge clk); req = 0;
    chk("R9", rdata, m_fe);
    req = 1; addr = AW'(4); @(posedge clk); @(negedge clk); req = 0;
    chk("R9", rdata, 32'd0);

    // R5: zero in bit 0 has no effect; upper bits ignored
    wr(4, 32'hFFFF_FFFE); rd(4);
    wr(4, 32'h1); rd(4); rd(1);
    wr(5, 32'h0); rd(4);
    wr(10, 32'h1); idle_chk_out();

    // concurrent: hw source 0 falls as software clears
    src[0] = 1; @(negedge clk);
    src[0] = 0;
    wr(5, 32'h1);
    rd(1); idle_chk_out();
    // sw set while hw high, then hw drops: bit 0 stays
    src[0] = 1; wr(4, 32'h1);
    src[0] = 0; @(negedge clk);
    rd(4); idle_chk_out();
    wr(5, 32'h1); idle_chk_out();

    // R8 write-only / undefined reads
    rd(3); rd(5); rd(11); rd(7); rd(63);

    // random mix
    for (int i = 0; i < 600; i++) begin
      int op = $urandom_range(0, 3);
      int a = alist[$urandom_range(0, 15)];
      logic [31:0] d = $urandom;
      if ($urandom_range(0, 3) == 0) d = 32'h1 << $urandom_range(0, 31);
      case (op)
        0: begin src = $urandom & $urandom; @(negedge clk); end
        1: wr(a, d);
        2: begin src = $urandom & $urandom & $urandom; wr(a, d); end
        default: rd(a);
      endcase
      idle_chk_out();
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule